// File: doc/BRIEF.md
# Dual-Processor Reset and Boot Configuration Controller

This block sequences reset for a system with two processors (more through a parameter). It sorts reset events into three classes, and each class clears a different part of the controller state. A cold reset comes from the power-on input and clears everything. A full reset comes from the reset pin, from software, or from a repeated watchdog timeout. It re-enables every processor and leaves only CPU0 running. A soft reset is requested by software. It keeps the per-processor disable bits, so the system comes back up with the disabled processors gated off.

Each processor has a reset output and a clock-enable output. The controller drives only these enables; the clock gating cells, the cores and the watchdog counter sit outside it. A clock enable changes only while the reset of that processor is asserted. A disable bit written by software therefore takes effect only at the next soft reboot. Software reaches the controller through a write port and a read port, each with a one-bit select. Select 0 is the configuration word and select 1 is a 64-bit scratch word. The hardware never uses the scratch word.

Configuration word layout, for the default two processors:

| Bit | Meaning |
|-----|---------|
| 0 | Software flag |
| 1 | Full reset request, write 1 |
| 2 | Soft reset request, write 1 |
| 3 | Watchdog first timeout, write 1 to clear |
| 4 | CPU0 disable |
| 5 | CPU1 disable |
| 6 | CPU0 release, always reads 1 |
| 7 | CPU1 release |

Top module: `cpu_reset_ctrl`

## Requirements
- R1: While `por_n` is low, both `cpu_rst` bits are 1. After the cold reset, the configuration word reads 0x40: the flag, the disable bits, the watchdog status and the CPU1 release are all 0. `cpu_clk_en` is 2'b11, CPU0 comes out of reset and CPU1 stays in reset.
- R2: Any of three events starts a full reset and asserts every `cpu_rst` bit: `rst_pin_n` low, a configuration write with bit 1 set, or a watchdog double timeout. `cpu_rst` reads 2'b11 at the first falling clock edge after the edge that sampled the event.
- R3: The reset outputs stay asserted until exactly 16 rising edges after the last edge that sampled a reset source, and they drop after that edge.
- R4: A full reset clears the disable bits, the CPU1 release bit and the watchdog status bit. It keeps the flag (bit 0) and the scratch word.
- R5: A configuration write with bit 2 set starts a soft reset. The soft reset clears the CPU1 release bit and keeps the disable bits, the flag and the scratch word.
- R6: During any reset, each `cpu_clk_en` bit takes the inverse of its disable bit, and a clock enable never changes while its `cpu_rst` bit is low. Writing a disable bit outside a reset leaves `cpu_clk_en` unchanged. A processor with its clock disabled keeps its `cpu_rst` bit at 1, even when its release bit is set.
- R7: Writing 1 to bit 7 (CPU1 release) outside a reset drops `cpu_rst[1]` after the write edge, provided CPU1's clock is enabled.
- R8: A first watchdog pulse sets bit 3 and does not start a reset. A pulse that arrives while bit 3 is set causes a full reset. Writing 1 to bit 3 clears it.
- R9: Bits 1 and 2 of the configuration word always read 0.
- R10: While a reset sequence is running, writes to either register and watchdog pulses have no effect.
- R11: The 64-bit scratch word reads back the value last written to select 1.
- R12: If bits 1 and 2 are written together, the full reset wins and the disable bits are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on (cold) reset, active low, synchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| wdog_tmo | input | 1 | Watchdog timeout pulse, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 scratch |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read target: 0 configuration, 1 scratch |
| rd_data | output | 64 | Read data, combinational from `rd_sel` |
| cpu_rst | output | NCPU | Per-processor reset, active high |
| cpu_clk_en | output | NCPU | Per-processor clock enable |

## Verification
Most internal faults reach the ports within one cycle. A wrong reset class shows up after the stretch, when the configuration word is read back: the disable bits or the release bit hold the wrong value, or the flag has been lost. It also shows up in `cpu_clk_en` or `cpu_rst[1]`. An off-by-one in the stretch counter moves the falling edge of `cpu_rst` away from the 16th edge. A watchdog status fault shows up either as a reset on the first pulse or as no reset on the second. A write that leaks through during a reset shows up as a changed configuration or scratch read once the sequence has finished.

// File: rtl/rcc_pkg.sv
// Package: shared field positions and the reset class type for the reset
// controller. Assumes the configuration word layout given in the brief.
package rcc_pkg;

    localparam int FLAG_BIT = 0;  // software flag
    localparam int SYS_BIT  = 1;  // full reset request (reads 0)
    localparam int SOFT_BIT = 2;  // soft reset request (reads 0)
    localparam int WDS_BIT  = 3;  // watchdog first-timeout status
    localparam int DIS_LSB  = 4;  // first per-processor disable bit

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SOFT = 2'd1,
        CLS_FULL = 2'd2
    } rst_class_e;

endpackage

// File: rtl/rcc_cause.sv
// Reset cause classifier: turns the pin, the software requests and the
// watchdog pulses into one reset class per cycle, and keeps the
// first-timeout status. Assumes the request inputs are already gated off
// while a sequence is busy.
module rcc_cause (
    input  logic                clk,
    input  logic                por_n,
    input  logic                busy,
    input  logic                rst_pin_n,
    input  logic                wdog_tmo,
    input  logic                sys_wr,
    input  logic                soft_wr,
    input  logic                wds_clr,
    output rcc_pkg::rst_class_e cls,
    output logic                wd_first
);
    import rcc_pkg::*;

    logic wd_double;

    // A second timeout outside a reset counts as the double timeout
    assign wd_double = wdog_tmo && wd_first && !busy;

    // Pick the reset class; a full reset outranks a soft one
    always_comb begin
        if (!rst_pin_n || sys_wr || wd_double) cls = CLS_FULL;
        else if (soft_wr)                      cls = CLS_SOFT;
        else                                   cls = CLS_NONE;
    end

    // First-timeout status: set by a lone pulse, cleared by a full reset or by software
    always_ff @(posedge clk) begin
        if (!por_n)                 wd_first <= 1'b0;
        else if (cls == CLS_FULL)   wd_first <= 1'b0;
        else if (!busy) begin
            if (wdog_tmo && !wd_first) wd_first <= 1'b1;
            else if (wds_clr)          wd_first <= 1'b0;
        end
    end

endmodule

// File: rtl/rcc_seq.sv
// Reset stretcher: keeps busy high while any source is present and for
// STRETCH edges after the last one. A cold reset reloads it as well.
module rcc_seq #(
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(STRETCH + 1);

    logic [CW-1:0] cnt_q;

    // Reload on any source, then count down and drop busy at zero
    always_ff @(posedge clk) begin
        if (!por_n || start) begin
            cnt_q <= CW'(STRETCH);
            busy  <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            busy  <= (cnt_q != CW'(1));
        end else begin
            busy  <= 1'b0;
        end
    end

endmodule

// File: rtl/rcc_cpu_gate.sv
// Per-processor gate: samples the clock enable only while the sequence is
// busy and combines busy, release and enable into the processor reset.
module rcc_cpu_gate (
    input  logic clk,
    input  logic por_n,
    input  logic busy,
    input  logic dis,
    input  logic rel,
    output logic clk_en,
    output logic rst
);

    // Clock enable follows the disable bit only during a reset sequence
    always_ff @(posedge clk) begin
        if (!por_n)    clk_en <= 1'b1;
        else if (busy) clk_en <= !dis;
    end

    // Held in reset while sequencing, while not released, or while gated off
    assign rst = busy || !rel || !clk_en;

endmodule

// File: rtl/cpu_reset_ctrl.sv
// Top of the reset controller: holds the configuration and scratch
// registers and connects the classifier, the stretcher and one gate per
// processor. Assumes all inputs are synchronous to clk. CPU0 is always
// released.
module cpu_reset_ctrl #(
    parameter int NCPU    = 2,
    parameter int STRETCH = 16,
    parameter int DW      = 64
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            rst_pin_n,
    input  logic            wdog_tmo,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic [NCPU-1:0] cpu_rst,
    output logic [NCPU-1:0] cpu_clk_en
);
    import rcc_pkg::*;

    localparam int REL_LSB = DIS_LSB + NCPU;
    localparam logic [NCPU-1:0] REL_BOOT = NCPU'(1);

    logic            busy;
    logic            cfg_wr, scr_wr;
    logic            wd_first;
    rst_class_e      cls;
    logic            flag_q;
    logic [NCPU-1:0] dis_q, rel_q;
    logic [DW-1:0]   scratch_q;
    logic [DW-1:0]   cfg_word;

    // Writes are accepted only outside a reset sequence
    assign cfg_wr = wr_en && !wr_sel && !busy;
    assign scr_wr = wr_en &&  wr_sel && !busy;

    rcc_cause u_cause (
        .clk       (clk),
        .por_n     (por_n),
        .busy      (busy),
        .rst_pin_n (rst_pin_n),
        .wdog_tmo  (wdog_tmo),
        .sys_wr    (cfg_wr && wr_data[SYS_BIT]),
        .soft_wr   (cfg_wr && wr_data[SOFT_BIT]),
        .wds_clr   (cfg_wr && wr_data[WDS_BIT]),
        .cls       (cls),
        .wd_first  (wd_first)
    );

    rcc_seq #(.STRETCH(STRETCH)) u_seq (
        .clk   (clk),
        .por_n (por_n),
        .start (cls != CLS_NONE),
        .busy  (busy)
    );

    // Configuration state: software writes first, then the reset class overrides
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag_q <= 1'b0;
            dis_q  <= '0;
            rel_q  <= REL_BOOT;
        end else begin
            if (cfg_wr) begin
                flag_q <= wr_data[FLAG_BIT];
                dis_q  <= wr_data[DIS_LSB +: NCPU];
                rel_q  <= wr_data[REL_LSB +: NCPU] | REL_BOOT;
            end
            if (cls == CLS_FULL) begin
                dis_q <= '0;
                rel_q <= REL_BOOT;
            end else if (cls == CLS_SOFT) begin
                rel_q <= REL_BOOT;
            end
        end
    end

    // Scratch word: kept across every reset, left unset by a cold one
    always_ff @(posedge clk) begin
        if (scr_wr) scratch_q <= wr_data;
    end

    // One gate per processor
    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        rcc_cpu_gate u_gate (
            .clk    (clk),
            .por_n  (por_n),
            .busy   (busy),
            .dis    (dis_q[g]),
            .rel    (rel_q[g]),
            .clk_en (cpu_clk_en[g]),
            .rst    (cpu_rst[g])
        );
    end

    // Assemble the configuration word; the request bits read as zero
    always_comb begin
        cfg_word                   = '0;
        cfg_word[FLAG_BIT]         = flag_q;
        cfg_word[WDS_BIT]          = wd_first;
        cfg_word[DIS_LSB +: NCPU]  = dis_q;
        cfg_word[REL_LSB +: NCPU]  = rel_q;
    end

    // Read mux
    assign rd_data = rd_sel ? scratch_q : cfg_word;

endmodule

// File: rtl/rcc_checker.sv
// Checker for cpu_reset_ctrl: relates the reset class, the sequence state
// and the outputs over time. Attached to the top through bind.
module rcc_checker #(
    parameter int NCPU = 2,
    parameter int DW   = 64
) (
    input logic                clk,
    input logic                por_n,
    input logic                rst_pin_n,
    input logic                wdog_tmo,
    input logic                busy,
    input logic                wd_first,
    input rcc_pkg::rst_class_e cls,
    input logic                flag_q,
    input logic [NCPU-1:0]     dis_q,
    input logic [NCPU-1:0]     rel_q,
    input logic                cfg_wr,
    input logic                rd_sel,
    input logic [DW-1:0]       rd_data,
    input logic [NCPU-1:0]     cpu_rst,
    input logic [NCPU-1:0]     cpu_clk_en
);
    import rcc_pkg::*;

    // R2: a low reset pin asserts every processor reset
    p_pin_holds_all_r2: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (&cpu_rst));

    // R6: a clock enable moves only while its reset was asserted
    p_clken_in_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |-> (((cpu_clk_en ^ $past(cpu_clk_en)) & ~$past(cpu_rst)) == '0));

    // R4: a full reset clears the disable bits, the release bits and the watchdog status
    p_full_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
        (cls == CLS_FULL) |=> (dis_q == '0 && rel_q[NCPU-1:1] == '0 && !wd_first));

    // R5: the flag changes only through an accepted write
    p_flag_kept_r5: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_wr |=> $stable(flag_q));

    // R8: a second timeout outside a reset starts a sequence
    p_double_tmo_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wdog_tmo && wd_first && !busy) |=> busy);

    // R8: a lone timeout only records the status bit
    p_single_tmo_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wdog_tmo && !wd_first && !busy && cls == CLS_NONE) |=> wd_first);

    // R9: the request bits never read back as one
    p_req_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
        !rd_sel |-> (rd_data[SOFT_BIT:SYS_BIT] == 2'b00));

endmodule

bind cpu_reset_ctrl rcc_checker #(.NCPU(NCPU), .DW(DW)) u_rcc_checker (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin_n  (rst_pin_n),
    .wdog_tmo   (wdog_tmo),
    .busy       (busy),
    .wd_first   (wd_first),
    .cls        (cls),
    .flag_q     (flag_q),
    .dis_q      (dis_q),
    .rel_q      (rel_q),
    .cfg_wr     (cfg_wr),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .cpu_rst    (cpu_rst),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/test_cpu_reset_ctrl.sv
// Bench for cpu_reset_ctrl: a register vector table followed by directed
// reset-class, watchdog and corner-case tests.
module test_cpu_reset_ctrl;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        wdog_tmo = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic [1:0]  cpu_rst;
    logic [1:0]  cpu_clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [63:0] SCR_A = 64'hDEAD_BEEF_0123_4567;

    // kind: 0 write cfg, 1 write scratch, 2 read cfg, 3 read scratch
    localparam logic [129:0] VEC [6] = '{
        {2'd1, SCR_A,         64'h0},
        {2'd3, 64'h0,         SCR_A},   // R11
        {2'd0, 64'h01,        64'h0},
        {2'd2, 64'h0,         64'h41},  // R9 request bits zero
        {2'd0, 64'h81,        64'h0},   // R7 release CPU1
        {2'd2, 64'h0,         64'hC1}
    };

    always #2 clk = ~clk;

    cpu_reset_ctrl i_cpu_reset_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdog_tmo(wdog_tmo),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .cpu_rst(cpu_rst), .cpu_clk_en(cpu_clk_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [63:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wdog_pulse();
        @(negedge clk);
        wdog_tmo = 1'b1;
        @(negedge clk);
        wdog_tmo = 1'b0;
    endtask

    // Count rising edges after the last source edge until cpu_rst[0] drops
    task automatic measure(output int n);
        n = 0;
        while (cpu_rst[0] && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int n;

        // R1: cold reset state
        repeat (3) @(negedge clk);
        check("R1 rst during por", 64'(cpu_rst), 64'h3);
        por_n = 1'b1;
        measure(n);
        check("R3 stretch after por", 64'(n), 64'd16);
        check("R1 cpu1 held", 64'(cpu_rst), 64'h2);
        check("R1 clk_en", 64'(cpu_clk_en), 64'h3);
        rd(1'b0, v);
        check("R1 cfg after cold", v, 64'h40);

        // Vector table
        foreach (VEC[i]) begin
            case (VEC[i][129:128])
                2'd0: wr(1'b0, VEC[i][127:64]);
                2'd1: wr(1'b1, VEC[i][127:64]);
                2'd2: begin rd(1'b0, v); check("R9 R11 table cfg", v, VEC[i][63:0]); end
                default: begin rd(1'b1, v); check("R11 table scratch", v, VEC[i][63:0]); end
            endcase
        end
        check("R7 cpu1 released", 64'(cpu_rst), 64'h0);

        // R6: disable write outside reset leaves clocks alone
        wr(1'b0, 64'hA1);
        check("R6 clk_en unchanged", 64'(cpu_clk_en), 64'h3);

        // R2/R4: pin reset
        @(negedge clk); rst_pin_n = 1'b0;
        @(negedge clk);
        check("R2 pin asserts reset", 64'(cpu_rst), 64'h3);
        repeat (2) @(negedge clk);
        rst_pin_n = 1'b1;
        measure(n);
        check("R3 stretch after pin", 64'(n), 64'd16);
        rd(1'b0, v);
        check("R4 cfg after full", v, 64'h41);
        rd(1'b1, v);
        check("R4 scratch kept", v, SCR_A);
        check("R4 clk_en", 64'(cpu_clk_en), 64'h3);

        // R5/R6: soft reset keeps CPU1 disabled
        wr(1'b0, 64'h25);
        measure(n);
        check("R3 stretch after soft", 64'(n), 64'd16);
        rd(1'b0, v);
        check("R5 cfg after soft", v, 64'h61);
        rd(1'b1, v);
        check("R5 scratch kept", v, SCR_A);
        check("R6 cpu1 clock off", 64'(cpu_clk_en), 64'h1);
        wr(1'b0, 64'hA1);
        check("R6 disabled cpu1 stays in reset", 64'(cpu_rst), 64'h2);

        // R2/R4: software full reset
        wr(1'b0, 64'h03);
        check("R2 sys bit asserts reset", 64'(cpu_rst), 64'h3);
        measure(n);
        rd(1'b0, v);
        check("R4 cfg after sys bit", v, 64'h41);
        check("R4 clk_en restored", 64'(cpu_clk_en), 64'h3);

        // R12: both requests, full wins
        wr(1'b0, 64'h27);
        measure(n);
        rd(1'b0, v);
        check("R12 full wins cfg", v, 64'h41);
        check("R12 full wins clk_en", 64'(cpu_clk_en), 64'h3);

        // R8: watchdog single, clear, double
        wdog_pulse();
        check("R8 single no reset", 64'(cpu_rst[0]), 64'h0);
        rd(1'b0, v);
        check("R8 status set", v, 64'h49);
        wr(1'b0, 64'h49);
        rd(1'b0, v);
        check("R8 status cleared", v, 64'h41);
        wdog_pulse();
        wdog_pulse();
        check("R2 R8 double asserts reset", 64'(cpu_rst), 64'h3);
        measure(n);
        check("R3 stretch after double", 64'(n), 64'd16);
        rd(1'b0, v);
        check("R8 cfg after double", v, 64'h41);

        // R10: writes and timeouts ignored while busy
        @(negedge clk); rst_pin_n = 1'b0;
        wr(1'b0, 64'hB0);
        wr(1'b1, 64'h5555);
        rst_pin_n = 1'b1;
        wdog_pulse();
        measure(n);
        rd(1'b0, v);
        check("R10 cfg write ignored", v, 64'h41);
        rd(1'b1, v);
        check("R10 scratch write ignored", v, SCR_A);

        // R1: cold reset clears the flag
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        measure(n);
        check("R3 stretch after second por", 64'(n), 64'd16);
        rd(1'b0, v);
        check("R1 flag cleared by cold", v, 64'h40);
        check("R1 cpu1 held after cold", 64'(cpu_rst), 64'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule